// File: doc/BRIEF.md
# Configurable Boolean Output Logic Engine

This block computes a bank of general-purpose outputs, each from its own small Boolean builder. A builder forms two product terms. Each term is the AND of whichever bits its select mask picks from one shared selection vector. That vector holds the input pins, the registered outputs of the whole bank, power-good flags, raw status flags and sticky copies of those status flags. The two terms then drive one of two things. The first is a top-level gate (AND, OR or NOR) whose result must stay steady for a programmable number of updates before the output follows. The second is a two-path alternating state machine that evaluates only when a selected input has changed.

Outputs are split into groups of eight. A group is re-evaluated only on its own slot of a free-running update divider, so every output in a group moves on the same clock edge. A simple write-only register port loads the masks, the modes, the delays, the list of rails that really have a voltage monitor, and the choice of input pin that may clear the sticky flags. A write to a strobe address also clears the sticky flags.

Top module: `lgpo_engine`

## Requirements
- R1: While reset is held and after it is released with the default configuration (all masks zero, mode AND, delay 0, no monitored rail, pin clear disabled), all outputs read 0.
- R2: The selection vector is {sticky[31:28], raw status[27:24], power-good[23:20], outputs[19:4], pins[3:0]}. A term is true only when its mask is non-zero and every selected bit is 1. A term with an all-zero mask is false.
- R3: Control field mode (bits 1:0) selects the gate: 0 = AND of the two terms, 1 = OR, 2 = NOR. With delay 0, the output takes the gate result at the group update that first sees it.
- R4: Control field delay (bits 9:2) = D > 0 means a new gate result reaches the output only at the D-th group update after the one that first saw it. Any change of the result in between restarts the count.
- R5: Mode 3 is the alternating machine, which starts on term 1. When an evaluation runs, the output is set to the active term. If term 1 is active and false, term 2 becomes active. If term 2 is active and true, term 1 becomes active.
- R6: In mode 3, an evaluation runs only at a group update where some bit selected by either mask differs from its value at that group's previous update. Changes to unselected bits have no effect.
- R7: Output k belongs to group k/8. A divider counts 0..3 from reset, advancing once per clock, and group g can change its outputs only on the edge at which the divider equals g.
- R8: Output bits in the selection vector are the registered outputs, so an output that selects another follows it one group update later.
- R9: A raw status bit that is 1 at a clock edge sets its sticky copy. The copy stays set until it is cleared.
- R10: Sticky bits are cleared by a write to address 49, or while the enabled clear pin is 1. A clear has no effect on a bit whose raw status is 1 in the same cycle.
- R11: Power-good bit i reads 0 in the selection vector unless monitor bit i is set in the global register.
- R12: Address 3k holds term-1 mask k, 3k+1 holds term-2 mask k, and 3k+2 holds control k. Address 48 is the global register: monitor bits [3:0], clear-pin enable bit 8, clear-pin index [13:12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpi | input | N_GPI | General-purpose input pin states |
| pgood | input | N_RAIL | Raw power-good flag per rail |
| flt_raw | input | N_FLT | Raw status flags from the fault detectors |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration write address |
| cfg_wdata | input | CFG_DW | Configuration write data |
| gpo | output | N_OUT | Registered logic-controlled outputs |

## Verification
The hardest state to reach is the alternating machine in path 2 while term 2 is already true. Continuous evaluation would make the output oscillate there, but change-gated evaluation must hold it low. The bench reaches it by moving both selected pins in the same cycle, from "term 1 true, term 2 false" straight to "term 1 false, term 2 true". It then toggles an unselected pin to show that no evaluation runs. The delay restart is reached with a pin pulse exactly four clocks long, so one group update sees the glitch. The clear-versus-set race is reached by issuing the clear strobe while the raw flag is still high.

// File: rtl/lgpo_pkg.sv
package lgpo_pkg;

   // Behaviour selector of one output builder
   typedef enum logic [1:0] {
      GATE_AND = 2'd0,
      GATE_OR  = 2'd1,
      GATE_NOR = 2'd2,
      ALT_FSM  = 2'd3
   } out_mode_e;

   // Fixed field positions inside the global register
   localparam int GLB_PEN_BIT = 8;
   localparam int GLB_PIDX_LO = 12;

endpackage

// File: rtl/lgpo_group_timer.sv
module lgpo_group_timer #(
   parameter int N_GRP   = 2,
   parameter int UPD_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [N_GRP-1:0] grp_tick
);
   localparam int CW = (UPD_DIV > 1) ? $clog2(UPD_DIV) : 1;

   logic [CW-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (div_q == CW'(UPD_DIV - 1)) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + CW'(1);
      end
   end

   for (genvar g = 0; g < N_GRP; g++) begin : g_tick
      assign grp_tick[g] = (div_q == CW'(g));
   end

endmodule

// File: rtl/lgpo_status_latch.sv
module lgpo_status_latch #(
   parameter int N_FLT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_FLT-1:0] flt_raw,
   input  logic             clr,
   output logic [N_FLT-1:0] lat_q
);
   // A raw flag active in the same cycle wins over the clear request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
      end else begin
         lat_q <= flt_raw | (lat_q & {N_FLT{~clr}});
      end
   end

endmodule

// File: rtl/lgpo_cfg_regs.sv
module lgpo_cfg_regs #(
   parameter int N_OUT  = 16,
   parameter int N_GPI  = 4,
   parameter int N_RAIL = 4,
   parameter int SEL_W  = 32,
   parameter int DLY_W  = 8,
   parameter int CFG_DW = 32,
   parameter int CFG_AW = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [CFG_AW-1:0]            cfg_addr,
   input  logic [CFG_DW-1:0]            cfg_wdata,
   input  logic [N_GPI-1:0]             gpi,
   output logic [N_OUT-1:0][SEL_W-1:0]  mask1_q,
   output logic [N_OUT-1:0][SEL_W-1:0]  mask2_q,
   output logic [N_OUT-1:0][1:0]        mode_q,
   output logic [N_OUT-1:0][DLY_W-1:0]  dly_q,
   output logic [N_RAIL-1:0]            mon_q,
   output logic                         lat_clr
);
   import lgpo_pkg::*;

   localparam int GPI_IW   = (N_GPI > 1) ? $clog2(N_GPI) : 1;
   localparam int ADDR_GLB = 3 * N_OUT;
   localparam int ADDR_CLR = 3 * N_OUT + 1;

   logic              pin_en_q;
   logic [GPI_IW-1:0] pin_idx_q;
   logic              wr_glb;
   logic              wr_clr;

   assign wr_glb = cfg_we && (cfg_addr == CFG_AW'(ADDR_GLB));
   assign wr_clr = cfg_we && (cfg_addr == CFG_AW'(ADDR_CLR));

   // Per-output register triplets
   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask1_q[k] <= '0;
            mask2_q[k] <= '0;
            mode_q[k]  <= GATE_AND;
            dly_q[k]   <= '0;
         end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(3 * k)) begin
               mask1_q[k] <= cfg_wdata[SEL_W-1:0];
            end
            if (cfg_addr == CFG_AW'(3 * k + 1)) begin
               mask2_q[k] <= cfg_wdata[SEL_W-1:0];
            end
            if (cfg_addr == CFG_AW'(3 * k + 2)) begin
               mode_q[k] <= cfg_wdata[1:0];
               dly_q[k]  <= cfg_wdata[2 +: DLY_W];
            end
         end
      end
   end

   // Global register: monitored rails and clear-pin selection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mon_q     <= '0;
         pin_en_q  <= 1'b0;
         pin_idx_q <= '0;
      end else if (wr_glb) begin
         mon_q     <= cfg_wdata[N_RAIL-1:0];
         pin_en_q  <= cfg_wdata[GLB_PEN_BIT];
         pin_idx_q <= cfg_wdata[GLB_PIDX_LO +: GPI_IW];
      end
   end

   assign lat_clr = wr_clr || (pin_en_q && gpi[pin_idx_q]);

endmodule

// File: rtl/lgpo_builder.sv
module lgpo_builder #(
   parameter int SEL_W = 32,
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   input  logic [SEL_W-1:0] snap,
   input  logic [SEL_W-1:0] mask1,
   input  logic [SEL_W-1:0] mask2,
   input  logic [1:0]       mode,
   input  logic [DLY_W-1:0] dly,
   output logic             out_q
);
   import lgpo_pkg::*;

   out_mode_e      mode_e;
   logic           term1;
   logic           term2;
   logic           gate_r;
   logic           trig;
   logic           path_q;     // 0: term 1 active, 1: term 2 active
   logic           cand_q;
   logic [DLY_W:0] cnt_q;
   logic [DLY_W:0] dly_x;
   logic [DLY_W:0] cnt_inc;

   assign mode_e  = out_mode_e'(mode);
   assign term1   = (mask1 != '0) && ((sel & mask1) == mask1);
   assign term2   = (mask2 != '0) && ((sel & mask2) == mask2);
   assign trig    = |((sel ^ snap) & (mask1 | mask2));
   assign dly_x   = {1'b0, dly};
   assign cnt_inc = cnt_q + (DLY_W+1)'(1);

   always_comb begin
      unique case (mode_e)
         GATE_AND: gate_r = term1 & term2;
         GATE_OR:  gate_r = term1 | term2;
         GATE_NOR: gate_r = ~(term1 | term2);
         default:  gate_r = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= 1'b0;
         path_q <= 1'b0;
         cand_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         if (mode_e != ALT_FSM) begin
            path_q <= 1'b0;
         end
         if (tick) begin
            if (mode_e == ALT_FSM) begin
               if (trig) begin
                  if (!path_q) begin
                     out_q <= term1;
                     if (!term1) path_q <= 1'b1;
                  end else begin
                     out_q <= term2;
                     if (term2) path_q <= 1'b0;
                  end
               end
            end else if (gate_r != cand_q) begin
               cand_q <= gate_r;
               cnt_q  <= '0;
               if (dly == '0) out_q <= gate_r;
            end else begin
               if (cnt_q < dly_x) cnt_q <= cnt_inc;
               if (cnt_inc >= dly_x) out_q <= cand_q;
            end
         end
      end
   end

endmodule

// File: rtl/lgpo_engine.sv
module lgpo_engine #(
   parameter int N_GPI    = 4,
   parameter int N_OUT    = 16,
   parameter int N_RAIL   = 4,
   parameter int N_FLT    = 4,
   parameter int GRP_SIZE = 8,
   parameter int UPD_DIV  = 4,
   parameter int DLY_W    = 8,
   parameter int CFG_DW   = 32,
   parameter int CFG_AW   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_GPI-1:0]  gpi,
   input  logic [N_RAIL-1:0] pgood,
   input  logic [N_FLT-1:0]  flt_raw,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic [N_OUT-1:0]  gpo
);
   localparam int SEL_W  = N_GPI + N_OUT + N_RAIL + 2 * N_FLT;
   localparam int N_GRP  = N_OUT / GRP_SIZE;
   localparam int GPI_IW = (N_GPI > 1) ? $clog2(N_GPI) : 1;

   // Elaboration-time parameter checks
   if (N_OUT % GRP_SIZE != 0) begin : g_bad_grp
      $error("N_OUT must be a multiple of GRP_SIZE");
   end
   if (N_GRP > UPD_DIV) begin : g_bad_div
      $error("UPD_DIV must provide one slot per group");
   end
   if (CFG_DW < SEL_W || CFG_DW < 2 + DLY_W) begin : g_bad_dw
      $error("CFG_DW too narrow for masks or control field");
   end
   if ((1 << CFG_AW) < 3 * N_OUT + 2) begin : g_bad_aw
      $error("CFG_AW too narrow for the register map");
   end
   if (N_RAIL > lgpo_pkg::GLB_PEN_BIT || lgpo_pkg::GLB_PIDX_LO + GPI_IW > CFG_DW) begin : g_bad_glb
      $error("global register fields overlap");
   end
   if ((1 << GPI_IW) != N_GPI) begin : g_bad_gpi
      $error("N_GPI must be a power of two");
   end

   logic [N_OUT-1:0][SEL_W-1:0] mask1;
   logic [N_OUT-1:0][SEL_W-1:0] mask2;
   logic [N_OUT-1:0][1:0]       mode;
   logic [N_OUT-1:0][DLY_W-1:0] dly;
   logic [N_RAIL-1:0]           mon;
   logic                        lat_clr;
   logic [N_FLT-1:0]            lat_q;
   logic [N_GRP-1:0]            grp_tick;
   logic [SEL_W-1:0]            sel_vec;
   logic [N_OUT-1:0]            out_w;

   lgpo_cfg_regs #(
      .N_OUT(N_OUT), .N_GPI(N_GPI), .N_RAIL(N_RAIL), .SEL_W(SEL_W),
      .DLY_W(DLY_W), .CFG_DW(CFG_DW), .CFG_AW(CFG_AW)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .gpi(gpi), .mask1_q(mask1), .mask2_q(mask2),
      .mode_q(mode), .dly_q(dly), .mon_q(mon), .lat_clr(lat_clr)
   );

   lgpo_status_latch #(.N_FLT(N_FLT)) u_lat (
      .clk(clk), .rst_n(rst_n), .flt_raw(flt_raw), .clr(lat_clr), .lat_q(lat_q)
   );

   lgpo_group_timer #(.N_GRP(N_GRP), .UPD_DIV(UPD_DIV)) u_tmr (
      .clk(clk), .rst_n(rst_n), .grp_tick(grp_tick)
   );

   // Outputs fed back from registers; rails without a monitor read not-good
   assign sel_vec = {lat_q, flt_raw, pgood & mon, out_w, gpi};
   assign gpo     = out_w;

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      logic [SEL_W-1:0] snap_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            snap_q <= '0;
         end else if (grp_tick[g]) begin
            snap_q <= sel_vec;
         end
      end

      for (genvar j = 0; j < GRP_SIZE; j++) begin : g_bld
         localparam int K = g * GRP_SIZE + j;
         lgpo_builder #(.SEL_W(SEL_W), .DLY_W(DLY_W)) u_bld (
            .clk(clk), .rst_n(rst_n), .tick(grp_tick[g]), .sel(sel_vec),
            .snap(snap_q), .mask1(mask1[K]), .mask2(mask2[K]),
            .mode(mode[K]), .dly(dly[K]), .out_q(out_w[K])
         );
      end
   end

endmodule

// File: rtl/lgpo_engine_chk.sv
module lgpo_engine_chk #(
   parameter int N_OUT    = 16,
   parameter int N_FLT    = 4,
   parameter int GRP_SIZE = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [N_OUT-1:0]          gpo,
   input logic [N_OUT/GRP_SIZE-1:0] grp_tick,
   input logic [N_FLT-1:0]          lat,
   input logic [N_FLT-1:0]          flt_raw,
   input logic                      clr
);
   localparam int N_GRP = N_OUT / GRP_SIZE;

   // R7
   one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grp_tick));

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      // R7
      grp_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (gpo[g*GRP_SIZE +: GRP_SIZE] != $past(gpo[g*GRP_SIZE +: GRP_SIZE]))
         |-> $past(grp_tick[g]));
   end

   for (genvar i = 0; i < N_FLT; i++) begin : g_flt
      // R9
      latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flt_raw[i] |=> lat[i]);
      // R9
      latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (lat[i] && !clr) |=> lat[i]);
      // R10
      latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !flt_raw[i]) |=> !lat[i]);
   end

endmodule

bind lgpo_engine lgpo_engine_chk #(
   .N_OUT(N_OUT), .N_FLT(N_FLT), .GRP_SIZE(GRP_SIZE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .gpo(gpo), .grp_tick(grp_tick),
   .lat(lat_q), .flt_raw(flt_raw), .clr(lat_clr)
);

// File: tb/test_lgpo_engine.sv
module test_lgpo_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  gpi = '0;
   logic [3:0]  pgood = '0;
   logic [3:0]  flt_raw = '0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [15:0] gpo;

   always #4 clk = ~clk;

   lgpo_engine i_lgpo_engine (
      .clk(clk), .rst_n(rst_n), .gpi(gpi), .pgood(pgood), .flt_raw(flt_raw),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gpo(gpo)
   );

   int    checks = 0;
   int    fails  = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // ---------------- behavioural reference ----------------
   logic [31:0] m_m1 [16];
   logic [31:0] m_m2 [16];
   int          m_mode [16];
   int          m_dly [16];
   bit          m_cand [16];
   int          m_cnt [16];
   bit          m_alt [16];
   logic [31:0] m_snap [2];
   logic [15:0] m_out;
   logic [3:0]  m_mon;
   bit          m_pen;
   int          m_pidx;
   logic [3:0]  m_lat;
   int          m_div;
   logic [31:0] s;
   logic [15:0] n_out;
   bit          t1, t2, r, clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 16; k++) begin
            m_m1[k] = '0; m_m2[k] = '0; m_mode[k] = 0; m_dly[k] = 0;
            m_cand[k] = 0; m_cnt[k] = 0; m_alt[k] = 0;
         end
         m_snap[0] = '0; m_snap[1] = '0;
         m_out = '0; m_mon = '0; m_pen = 0; m_pidx = 0; m_lat = '0; m_div = 0;
      end else begin
         s = {m_lat, flt_raw, pgood & m_mon, m_out, gpi};
         n_out = m_out;
         for (int k = 0; k < 16; k++) begin
            t1 = (m_m1[k] != 0) && ((s & m_m1[k]) == m_m1[k]);
            t2 = (m_m2[k] != 0) && ((s & m_m2[k]) == m_m2[k]);
            if (m_mode[k] != 3) m_alt[k] = 0;
            if (m_div == k / 8) begin
               if (m_mode[k] == 3) begin
                  if (((s ^ m_snap[k/8]) & (m_m1[k] | m_m2[k])) != 0) begin
                     if (!m_alt[k]) begin
                        n_out[k] = t1;
                        if (!t1) m_alt[k] = 1;
                     end else begin
                        n_out[k] = t2;
                        if (t2) m_alt[k] = 0;
                     end
                  end
               end else begin
                  if (m_mode[k] == 0)      r = t1 && t2;
                  else if (m_mode[k] == 1) r = t1 || t2;
                  else                     r = !(t1 || t2);
                  if (r != m_cand[k]) begin
                     m_cand[k] = r;
                     m_cnt[k] = 0;
                     if (m_dly[k] == 0) n_out[k] = r;
                  end else begin
                     if (m_cnt[k] < m_dly[k]) m_cnt[k]++;
                     if (m_cnt[k] >= m_dly[k]) n_out[k] = m_cand[k];
                  end
               end
            end
         end
         if (m_div < 2) m_snap[m_div] = s;
         clr = (cfg_we && cfg_addr == 6'd49) || (m_pen && gpi[m_pidx]);
         m_lat = flt_raw | (clr ? 4'b0 : m_lat);
         m_out = n_out;
         if (cfg_we) begin
            if (cfg_addr < 6'd48) begin
               case (int'(cfg_addr) % 3)
                  0: m_m1[cfg_addr/3] = cfg_wdata;
                  1: m_m2[cfg_addr/3] = cfg_wdata;
                  default: begin
                     m_mode[cfg_addr/3] = int'(cfg_wdata[1:0]);
                     m_dly[cfg_addr/3]  = int'(cfg_wdata[9:2]);
                  end
               endcase
            end else if (cfg_addr == 6'd48) begin
               m_mon = cfg_wdata[3:0];
               m_pen = cfg_wdata[8];
               m_pidx = int'(cfg_wdata[13:12]);
            end
         end
         m_div = (m_div + 1) % 4;
      end
   end

   // Every-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (gpo !== m_out) begin
            fails++;
            $display("FAIL %s gpo actual=%h expected=%h", cur_req, gpo, m_out);
         end
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic report;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
   end

   initial begin
      int c0, c1, c12;
      // R1 reset state
      cyc(3);
      chk("R1", gpo == 16'h0, 1'b1);
      @(negedge clk); rst_n = 1'b1;
      cyc(8);
      chk("R1", gpo == 16'h0, 1'b1);

      // R2 / R3: gates and zero masks
      cur_req = "R3";
      wr(0, 1); wr(1, 2); wr(2, 0);
      wr(3, 1); wr(4, 2); wr(5, 1);
      wr(6, 1); wr(7, 2); wr(8, 2);
      wr(23, 2);
      for (int p = 0; p < 4; p++) begin
         @(negedge clk); gpi[1:0] = 2'(p);
         cyc(10);
         chk("R3", gpo[0], p == 3);
         chk("R3", gpo[1], p != 0);
         chk("R3", gpo[2], p == 0);
         chk("R2", gpo[3], 1'b0);
         chk("R2", gpo[7], 1'b1);
      end
      @(negedge clk); gpi = '0;

      // R12 address map
      cur_req = "R12";
      wr(47, 2);
      cyc(10);
      chk("R12", gpo[15], 1'b1);
      chk("R12", gpo[14], 1'b0);

      // R7 group timing
      cur_req = "R7";
      wr(36, 1); wr(37, 2); wr(38, 0);
      cyc(10);
      c0 = -1; c1 = -1; c12 = -1;
      @(negedge clk); gpi[1:0] = 2'b11;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (gpo[0] && c0 < 0) c0 = i;
         if (gpo[1] && c1 < 0) c1 = i;
         if (gpo[12] && c12 < 0) c12 = i;
      end
      chk("R7", c0 == c1 && c0 >= 0, 1'b1);
      chk("R7", ((c12 - c0 + 4) % 4) == 1, 1'b1);

      // R8 feedback of registered outputs
      cur_req = "R8";
      wr(27, 32'h10); wr(29, 1);
      cyc(10);
      chk("R8", gpo[9], 1'b1);
      @(negedge clk); gpi = '0;
      cyc(12);
      chk("R8", gpo[9], 1'b0);

      // R4 delay with restart
      cur_req = "R4";
      wr(12, 32'h4); wr(14, (3 << 2) | 1);
      cyc(10);
      @(negedge clk); gpi[2] = 1'b1;
      cyc(5);
      chk("R4", gpo[4], 1'b0);
      cyc(12);
      chk("R4", gpo[4], 1'b1);
      @(negedge clk); gpi[2] = 1'b0;
      cyc(3);
      @(negedge clk); gpi[2] = 1'b1;
      cyc(20);
      chk("R4", gpo[4], 1'b1);
      @(negedge clk); gpi[2] = 1'b0;
      cyc(20);
      chk("R4", gpo[4], 1'b0);

      // R5 / R6 alternating machine on output 8
      cur_req = "R5";
      wr(24, 1); wr(25, 2); wr(26, 3);
      cyc(10);
      @(negedge clk); gpi[1:0] = 2'b01; cyc(10);
      chk("R5", gpo[8], 1'b1);
      @(negedge clk); gpi[1:0] = 2'b00; cyc(10);
      chk("R5", gpo[8], 1'b0);
      @(negedge clk); gpi[1:0] = 2'b01; cyc(10);
      chk("R5", gpo[8], 1'b0);
      @(negedge clk); gpi[1:0] = 2'b11; cyc(10);
      chk("R5", gpo[8], 1'b1);
      @(negedge clk); gpi[1:0] = 2'b01; cyc(10);
      chk("R5", gpo[8], 1'b1);
      cur_req = "R6";
      @(negedge clk); gpi[1:0] = 2'b10; cyc(20);
      chk("R6", gpo[8], 1'b0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); gpi[3] = ~gpi[3];
         cyc(5);
      end
      chk("R6", gpo[8], 1'b0);
      @(negedge clk); gpi = '0;
      cyc(10);

      // R9 / R10 sticky flags
      cur_req = "R9";
      wr(15, 32'h1000_0000); wr(17, 1);
      wr(30, 32'h0100_0000); wr(32, 1);
      wr(18, 32'h0010_0000); wr(20, 1);
      cyc(8);
      @(negedge clk); flt_raw[0] = 1'b1;
      cyc(2);
      flt_raw[0] = 1'b0;
      cyc(10);
      chk("R9", gpo[5], 1'b1);
      chk("R9", gpo[10], 1'b0);
      cur_req = "R10";
      wr(49, 0);
      cyc(10);
      chk("R10", gpo[5], 1'b0);
      @(negedge clk); flt_raw[0] = 1'b1;
      wr(49, 0);
      flt_raw[0] = 1'b0;
      cyc(10);
      chk("R10", gpo[5], 1'b1);
      wr(48, (1 << 8) | (3 << 12));
      @(negedge clk); gpi[3] = 1'b1;
      @(negedge clk); gpi[3] = 1'b0;
      cyc(10);
      chk("R10", gpo[5], 1'b0);

      // R11 unmonitored rails never good
      cur_req = "R11";
      @(negedge clk); pgood = 4'hF;
      cyc(10);
      chk("R11", gpo[6], 1'b0);
      wr(48, 1);
      cyc(10);
      chk("R11", gpo[6], 1'b1);
      wr(48, 32'hE);
      cyc(10);
      chk("R11", gpo[6], 1'b0);

      report();
      $finish;
   end

endmodule